// File: doc/BRIEF.md
# Zero-Overhead Loop Controller

This block keeps the hardware loop state of a 32-bit in-order core. It holds three registers: the loop-begin address, the loop-end address and the remaining repeat count. Decode hands it one of two setup commands, each with the address of the setup instruction. A counted setup also carries a general-register value and a displacement. An endless setup carries only a displacement. The block computes the begin address, the end address and, for a counted loop, the count from that command.

Each retiring instruction presents its address. When a loop is armed and the address hits the loop end, the block raises a redirect toward the loop begin in the same cycle. Otherwise it lets execution fall through. Bit 0 of the end register records the loop kind: 1 for endless, 0 for counted. Software can save and restore all three registers through a small control-register port.

The sequencer has three states. LOOP_IDLE means no loop is armed. LOOP_COUNTED means a counted loop is armed. LOOP_ENDLESS means an endless loop is armed. The transitions are:
- ARM_COUNTED: a counted setup, from any state, goes to LOOP_COUNTED.
- ARM_ENDLESS: an endless setup, from any state, goes to LOOP_ENDLESS.
- RESTORE: a control write to the end register goes to LOOP_ENDLESS when the written bit 0 is 1, and to LOOP_COUNTED when it is 0.
- EXHAUST: in LOOP_COUNTED, a hit while the count is zero goes to LOOP_IDLE.

A hit in LOOP_ENDLESS keeps the state where it is. A hit in LOOP_COUNTED with a nonzero count also keeps the state.

Top module: `zol_ctrl`

## Requirements
- R1: After reset, the begin, end and count registers read 0, `loop_active` is 0, and no redirect is raised.
- R2: Either setup command loads the begin register with the setup address plus 4.
- R3: A counted setup loads the end register with the setup address plus the displacement, with bit 0 of the result cleared. It also loads the count register from `setup_count`.
- R4: An endless setup loads the end register with the setup address plus the displacement, with bit 0 set to 1. It leaves the count register unchanged.
- R5: A redirect is raised in the same cycle when all of these hold: `retire_valid` is 1, a loop is armed, and bits 31..1 of `retire_pc` equal bits 31..1 of the end register. When it is raised, `redirect_pc` equals the begin register. With `retire_valid` at 0, or with any other address, no redirect is raised.
- R6: In a counted loop, a hit with a nonzero count redirects and lowers the count by 1. A hit with count 0 does not redirect and disarms the loop. A count of N therefore yields exactly N redirects.
- R7: In an endless loop, every hit redirects, and the count register never changes.
- R8: The control port selects a register with `creg_sel`: 0 is begin, 1 is end, 2 is count. Reads are combinational. Selector 3 reads 0, and a write to it changes nothing.
- R9: A control write to the end register arms the loop. Written bit 0 = 1 arms an endless loop, and bit 0 = 0 arms a counted loop. Bit 0 of the end register always matches the armed kind.
- R10: A setup command takes priority over a control write and over the count decrement in the same cycle. A retire in that same cycle is judged against the registers held before the setup.
- R11: While no loop is armed, an address equal to the end register raises no redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| setup_valid | input | 1 | A loop setup command is present this cycle |
| setup_endless | input | 1 | 1 for an endless setup, 0 for a counted setup |
| setup_pc | input | 32 | Address of the setup instruction |
| setup_disp | input | 32 | Sign-extended displacement to the loop end |
| setup_count | input | 32 | General-register value used as the repeat count |
| retire_valid | input | 1 | An instruction retires this cycle |
| retire_pc | input | 32 | Address of the retiring instruction |
| redirect_valid | output | 1 | Fetch must go to `redirect_pc` |
| redirect_pc | output | 32 | Loop begin address |
| creg_sel | input | 2 | Control register select |
| creg_we | input | 1 | Control register write strobe |
| creg_wdata | input | 32 | Control register write data |
| creg_rdata | output | 32 | Control register read data |
| loop_active | output | 1 | A loop is armed |

## Verification
The interesting overlap is a setup command in the same cycle as a retire that hits the end of the loop already running. The bench provokes it twice. In the first case a live counted loop meets an endless setup: the redirect must still point at the old begin address, and the count must keep its old value with no decrement. In the second case an exhausted counted loop meets a new counted setup: no redirect may appear, yet the new loop must be armed with the new count. A control write to begin is issued in that same cycle, and it must lose to the setup. All expectations come from an arithmetic model that walks the retire addresses through each loop body. The counted-loop sweep crosses repeat counts 0 to 5 with body lengths 1 to 3 instructions.

// File: rtl/zol_pkg.sv
package zol_pkg;

    // Sequencer states.
    typedef enum logic [1:0] {
        ZS_IDLE    = 2'd0,
        ZS_COUNTED = 2'd1,
        ZS_ENDLESS = 2'd2
    } zol_state_e;

    // Control register selector codes.
    localparam int          CSEL_W     = 2;
    localparam logic [1:0]  CSEL_BEGIN = 2'd0;
    localparam logic [1:0]  CSEL_END   = 2'd1;
    localparam logic [1:0]  CSEL_COUNT = 2'd2;

    // Distance from the setup instruction to the first instruction of the body.
    localparam int          FETCH_STEP = 4;

endpackage

// File: rtl/zol_target_calc.sv
module zol_target_calc
    import zol_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] pc,
    input  logic [XLEN-1:0] disp,
    input  logic            endless,
    output logic [XLEN-1:0] begin_addr,
    output logic [XLEN-1:0] end_addr
);

    logic [XLEN-1:0] disp_even;
    logic [XLEN-1:0] end_sum;

    always_comb begin
        disp_even  = {disp[XLEN-1:1], 1'b0};
        end_sum    = pc + disp_even;
        begin_addr = pc + XLEN'(FETCH_STEP);
        // Bit 0 of the end address carries the loop kind.
        end_addr   = {end_sum[XLEN-1:1], endless};
    end

endmodule

// File: rtl/zol_end_match.sv
module zol_end_match #(
    parameter int XLEN = 32
) (
    input  logic            retire_valid,
    input  logic [XLEN-1:0] retire_pc,
    input  logic [XLEN-1:0] end_q,
    input  logic            armed,
    output logic            hit
);

    localparam int CMP_W = XLEN - 1;

    logic [CMP_W-1:0] pc_word;
    logic [CMP_W-1:0] end_word;

    always_comb begin
        // Bit 0 is ignored on both sides of the compare.
        pc_word  = retire_pc[XLEN-1:1];
        end_word = end_q[XLEN-1:1];
        hit      = retire_valid && armed && (pc_word == end_word);
    end

endmodule

// File: rtl/zol_seq.sv
module zol_seq
    import zol_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       setup_valid,
    input  logic       setup_endless,
    input  logic       end_write,
    input  logic       end_write_mode,
    input  logic       hit,
    input  logic       count_zero,
    output zol_state_e state_o,
    output logic       redirect,
    output logic       count_dec,
    output logic       active
);

    zol_state_e state_q;
    zol_state_e state_d;

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        if (setup_valid) begin
            state_d = setup_endless ? ZS_ENDLESS : ZS_COUNTED;   // ARM_ENDLESS / ARM_COUNTED
        end else if (end_write) begin
            state_d = end_write_mode ? ZS_ENDLESS : ZS_COUNTED;  // RESTORE
        end else begin
            unique case (state_q)
                ZS_IDLE:    state_d = ZS_IDLE;
                ZS_COUNTED: state_d = (hit && count_zero) ? ZS_IDLE : ZS_COUNTED;  // EXHAUST
                ZS_ENDLESS: state_d = ZS_ENDLESS;
                default:    state_d = ZS_IDLE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ZS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs.
    always_comb begin
        redirect  = 1'b0;
        count_dec = 1'b0;
        active    = 1'b0;
        unique case (state_q)
            ZS_IDLE: begin
                active = 1'b0;
            end
            ZS_COUNTED: begin
                active    = 1'b1;
                redirect  = hit && !count_zero;
                count_dec = hit && !count_zero;
            end
            ZS_ENDLESS: begin
                active   = 1'b1;
                redirect = hit;
            end
            default: begin
                active = 1'b0;
            end
        endcase
    end

    assign state_o = state_q;

endmodule

// File: rtl/zol_ctrl.sv
module zol_ctrl
    import zol_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            setup_valid,
    input  logic            setup_endless,
    input  logic [XLEN-1:0] setup_pc,
    input  logic [XLEN-1:0] setup_disp,
    input  logic [XLEN-1:0] setup_count,
    input  logic            retire_valid,
    input  logic [XLEN-1:0] retire_pc,
    output logic            redirect_valid,
    output logic [XLEN-1:0] redirect_pc,
    input  logic [1:0]      creg_sel,
    input  logic            creg_we,
    input  logic [XLEN-1:0] creg_wdata,
    output logic [XLEN-1:0] creg_rdata,
    output logic            loop_active
);

    logic [XLEN-1:0] begin_q;
    logic [XLEN-1:0] end_q;
    logic [XLEN-1:0] count_q;
    logic [XLEN-1:0] calc_begin;
    logic [XLEN-1:0] calc_end;
    logic            hit;
    logic            count_zero;
    logic            count_dec;
    logic            wr_begin;
    logic            wr_end;
    logic            wr_count;
    zol_state_e      state_q;

    assign wr_begin   = creg_we && (creg_sel == CSEL_BEGIN);
    assign wr_end     = creg_we && (creg_sel == CSEL_END);
    assign wr_count   = creg_we && (creg_sel == CSEL_COUNT);
    assign count_zero = (count_q == '0);

    zol_target_calc #(.XLEN(XLEN)) u_calc (
        .pc         (setup_pc),
        .disp       (setup_disp),
        .endless    (setup_endless),
        .begin_addr (calc_begin),
        .end_addr   (calc_end)
    );

    zol_end_match #(.XLEN(XLEN)) u_match (
        .retire_valid (retire_valid),
        .retire_pc    (retire_pc),
        .end_q        (end_q),
        .armed        (loop_active),
        .hit          (hit)
    );

    zol_seq u_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .setup_valid    (setup_valid),
        .setup_endless  (setup_endless),
        .end_write      (wr_end),
        .end_write_mode (creg_wdata[0]),
        .hit            (hit),
        .count_zero     (count_zero),
        .state_o        (state_q),
        .redirect       (redirect_valid),
        .count_dec      (count_dec),
        .active         (loop_active)
    );

    // Loop registers. Priority: setup, then control write, then decrement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            begin_q <= '0;
            end_q   <= '0;
            count_q <= '0;
        end else begin
            if (setup_valid) begin
                begin_q <= calc_begin;
            end else if (wr_begin) begin
                begin_q <= creg_wdata;
            end

            if (setup_valid) begin
                end_q <= calc_end;
            end else if (wr_end) begin
                end_q <= creg_wdata;
            end

            if (setup_valid && !setup_endless) begin
                count_q <= setup_count;
            end else if (setup_valid) begin
                count_q <= count_q;
            end else if (wr_count) begin
                count_q <= creg_wdata;
            end else if (count_dec) begin
                count_q <= count_q - XLEN'(1);
            end
        end
    end

    // Control register read mux.
    always_comb begin
        case (creg_sel)
            CSEL_BEGIN: creg_rdata = begin_q;
            CSEL_END:   creg_rdata = end_q;
            CSEL_COUNT: creg_rdata = count_q;
            default:    creg_rdata = '0;
        endcase
    end

    assign redirect_pc = begin_q;

endmodule

// File: rtl/zol_ctrl_chk.sv
module zol_ctrl_chk
    import zol_pkg::*;
#(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            setup_valid,
    input logic [XLEN-1:0] setup_pc,
    input logic            creg_we,
    input logic            retire_valid,
    input logic [XLEN-1:0] retire_pc,
    input logic            redirect_valid,
    input logic            loop_active,
    input logic [XLEN-1:0] begin_q,
    input logic [XLEN-1:0] end_q,
    input logic [XLEN-1:0] count_q,
    input zol_state_e      state_q,
    input logic            hit
);

    AST_REDIRECT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |-> (retire_valid && loop_active)); // R11

    AST_REDIRECT_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |-> (retire_pc[XLEN-1:1] == end_q[XLEN-1:1])); // R5

    AST_SETUP_BEGIN: assert property (@(posedge clk) disable iff (!rst_n)
        setup_valid |=> (begin_q == $past(setup_pc) + XLEN'(4))); // R2

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ZS_COUNTED && redirect_valid && !setup_valid && !creg_we)
        |=> (count_q == $past(count_q) - XLEN'(1))); // R6

    AST_EXHAUST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ZS_COUNTED && hit && count_q == '0 && !setup_valid && !creg_we)
        |=> !loop_active); // R6

    AST_ENDLESS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ZS_ENDLESS && !setup_valid && !creg_we) |=> $stable(count_q)); // R7

    AST_MODE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        loop_active |-> (end_q[0] == (state_q == ZS_ENDLESS))); // R9

endmodule

bind zol_ctrl zol_ctrl_chk #(.XLEN(XLEN)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .setup_valid    (setup_valid),
    .setup_pc       (setup_pc),
    .creg_we        (creg_we),
    .retire_valid   (retire_valid),
    .retire_pc      (retire_pc),
    .redirect_valid (redirect_valid),
    .loop_active    (loop_active),
    .begin_q        (begin_q),
    .end_q          (end_q),
    .count_q        (count_q),
    .state_q        (state_q),
    .hit            (hit)
);

// File: tb/zol_ctrl_test.sv
`timescale 1ns/1ps
module zol_ctrl_test;

    localparam int XLEN = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            setup_valid = 1'b0;
    logic            setup_endless = 1'b0;
    logic [XLEN-1:0] setup_pc = '0;
    logic [XLEN-1:0] setup_disp = '0;
    logic [XLEN-1:0] setup_count = '0;
    logic            retire_valid = 1'b0;
    logic [XLEN-1:0] retire_pc = '0;
    logic            redirect_valid;
    logic [XLEN-1:0] redirect_pc;
    logic [1:0]      creg_sel = 2'd0;
    logic            creg_we = 1'b0;
    logic [XLEN-1:0] creg_wdata = '0;
    logic [XLEN-1:0] creg_rdata;
    logic            loop_active;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    zol_ctrl #(.XLEN(XLEN)) uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .setup_valid    (setup_valid),
        .setup_endless  (setup_endless),
        .setup_pc       (setup_pc),
        .setup_disp     (setup_disp),
        .setup_count    (setup_count),
        .retire_valid   (retire_valid),
        .retire_pc      (retire_pc),
        .redirect_valid (redirect_valid),
        .redirect_pc    (redirect_pc),
        .creg_sel       (creg_sel),
        .creg_we        (creg_we),
        .creg_wdata     (creg_wdata),
        .creg_rdata     (creg_rdata),
        .loop_active    (loop_active)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string req, input string what,
                       input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // One cycle: drive at the falling edge, sample combinational outputs
    // 1 ns later, release everything just after the rising edge.
    task automatic drive(input logic sv, input logic se, input logic [XLEN-1:0] spc,
                         input logic [XLEN-1:0] sdisp, input logic [XLEN-1:0] scnt,
                         input logic we, input logic [1:0] sel, input logic [XLEN-1:0] wd,
                         input logic rv, input logic [XLEN-1:0] rpc,
                         output logic rd, output logic [XLEN-1:0] tg);
        @(negedge clk);
        setup_valid = sv; setup_endless = se; setup_pc = spc;
        setup_disp = sdisp; setup_count = scnt;
        creg_we = we; creg_sel = sel; creg_wdata = wd;
        retire_valid = rv; retire_pc = rpc;
        #1;
        rd = redirect_valid;
        tg = redirect_pc;
        @(posedge clk);
        #1;
        setup_valid = 1'b0; creg_we = 1'b0; retire_valid = 1'b0;
    endtask

    task automatic rd_creg(input logic [1:0] sel, output logic [XLEN-1:0] d);
        @(negedge clk);
        creg_sel = sel;
        #1;
        d = creg_rdata;
    endtask

    task automatic setup_cmd(input logic se, input logic [XLEN-1:0] spc,
                             input logic [XLEN-1:0] sdisp, input logic [XLEN-1:0] scnt);
        logic r; logic [XLEN-1:0] t;
        drive(1'b1, se, spc, sdisp, scnt, 1'b0, 2'd0, '0, 1'b0, '0, r, t);
    endtask

    task automatic creg_wr(input logic [1:0] sel, input logic [XLEN-1:0] d);
        logic r; logic [XLEN-1:0] t;
        drive(1'b0, 1'b0, '0, '0, '0, 1'b1, sel, d, 1'b0, '0, r, t);
    endtask

    task automatic retire(input logic rv, input logic [XLEN-1:0] pc,
                          output logic rd, output logic [XLEN-1:0] tg);
        drive(1'b0, 1'b0, '0, '0, '0, 1'b0, 2'd0, '0, rv, pc, rd, tg);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic            r;
        logic [XLEN-1:0] t;
        logic [XLEN-1:0] d;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd_creg(2'd0, d); chk("R1", "begin after reset", d, 32'h0);
        rd_creg(2'd1, d); chk("R1", "end after reset", d, 32'h0);
        rd_creg(2'd2, d); chk("R1", "count after reset", d, 32'h0);
        chk("R1", "active after reset", {31'b0, loop_active}, 32'h0);
        // R11: end register is 0, retire at 0 while idle
        retire(1'b1, 32'h0, r, t);
        chk("R11", "redirect while idle", {31'b0, r}, 32'h0);

        // R2 R3 R5 R6: counted loop sweep
        for (int n = 0; n <= 5; n++) begin
            for (int body = 1; body <= 3; body++) begin
                logic [XLEN-1:0] pc0, disp, eb, ee, pc;
                int cnt;
                bit act;
                pc0  = 32'h1000 + 32'h100 * n + 32'h20 * body;
                disp = 32'(4 * body) | ((body == 2) ? 32'h1 : 32'h0);
                eb   = pc0 + 32'h4;
                ee   = pc0 + 32'(4 * body);
                setup_cmd(1'b0, pc0, disp, 32'(n));
                rd_creg(2'd0, d); chk("R2", "counted begin", d, eb);
                rd_creg(2'd1, d); chk("R3", "counted end", d, ee);
                rd_creg(2'd2, d); chk("R3", "counted count", d, 32'(n));
                cnt = n; act = 1'b1; pc = eb;
                for (int s = 0; s < (n + 1) * body + 2 && act; s++) begin
                    retire(1'b1, pc, r, t);
                    if (pc == ee) begin
                        if (cnt > 0) begin
                            chk("R6", "redirect at end", {31'b0, r}, 32'h1);
                            chk("R5", "redirect target", t, eb);
                            cnt--; pc = eb;
                        end else begin
                            chk("R6", "no redirect when exhausted", {31'b0, r}, 32'h0);
                            act = 1'b0;
                        end
                    end else begin
                        chk("R5", "no redirect inside body", {31'b0, r}, 32'h0);
                        pc = pc + 32'h4;
                    end
                end
                chk("R6", "inactive after exhaust", {31'b0, loop_active}, 32'h0);
                rd_creg(2'd2, d); chk("R6", "count after exhaust", d, 32'h0);
            end
        end

        // R4 R7: endless loop, count preloaded by control write
        creg_wr(2'd2, 32'h7);
        setup_cmd(1'b1, 32'h2000, 32'h0C, 32'h55);
        rd_creg(2'd0, d); chk("R2", "endless begin", d, 32'h2004);
        rd_creg(2'd1, d); chk("R4", "endless end", d, 32'h200D);
        rd_creg(2'd2, d); chk("R4", "endless keeps count", d, 32'h7);
        for (int p = 0; p < 4; p++) begin
            for (int k = 0; k < 3; k++) begin
                retire(1'b1, 32'h2004 + 32'(4 * k), r, t);
                chk("R7", "endless redirect pattern", {31'b0, r}, (k == 2) ? 32'h1 : 32'h0);
                if (k == 2) chk("R7", "endless target", t, 32'h2004);
            end
        end
        rd_creg(2'd2, d); chk("R7", "endless count unchanged", d, 32'h7);
        retire(1'b0, 32'h200C, r, t);
        chk("R5", "no redirect without retire", {31'b0, r}, 32'h0);
        retire(1'b1, 32'h2010, r, t);
        chk("R5", "no redirect past end", {31'b0, r}, 32'h0);

        // R8 R9: control port
        creg_wr(2'd2, 32'h2);
        creg_wr(2'd0, 32'h3000);
        creg_wr(2'd1, 32'h3010);
        chk("R9", "end write arms counted", {31'b0, loop_active}, 32'h1);
        rd_creg(2'd0, d); chk("R8", "read begin", d, 32'h3000);
        rd_creg(2'd1, d); chk("R8", "read end", d, 32'h3010);
        rd_creg(2'd2, d); chk("R8", "read count", d, 32'h2);
        retire(1'b1, 32'h3010, r, t); chk("R9", "restored redirect 1", {31'b0, r}, 32'h1);
        chk("R9", "restored target", t, 32'h3000);
        retire(1'b1, 32'h3010, r, t); chk("R9", "restored redirect 2", {31'b0, r}, 32'h1);
        retire(1'b1, 32'h3010, r, t); chk("R9", "restored exhaust", {31'b0, r}, 32'h0);
        chk("R9", "inactive after restored exhaust", {31'b0, loop_active}, 32'h0);
        creg_wr(2'd3, 32'hFFFF_FFFF);
        rd_creg(2'd3, d); chk("R8", "selector 3 reads zero", d, 32'h0);
        rd_creg(2'd0, d); chk("R8", "begin after sel3 write", d, 32'h3000);
        rd_creg(2'd1, d); chk("R8", "end after sel3 write", d, 32'h3010);
        rd_creg(2'd2, d); chk("R8", "count after sel3 write", d, 32'h0);
        chk("R8", "sel3 write leaves idle", {31'b0, loop_active}, 32'h0);
        creg_wr(2'd1, 32'h4011);
        chk("R9", "end write arms endless", {31'b0, loop_active}, 32'h1);
        for (int k = 0; k < 3; k++) begin
            retire(1'b1, 32'h4010, r, t);
            chk("R9", "restored endless redirect", {31'b0, r}, 32'h1);
        end
        rd_creg(2'd2, d); chk("R9", "restored endless count", d, 32'h0);

        // R10: setup colliding with a hit
        setup_cmd(1'b0, 32'h5000, 32'h8, 32'h3);
        drive(1'b1, 1'b1, 32'h6000, 32'h10, 32'h0, 1'b0, 2'd0, '0, 1'b1, 32'h5008, r, t);
        chk("R10", "old loop redirects", {31'b0, r}, 32'h1);
        chk("R10", "old loop target", t, 32'h5004);
        rd_creg(2'd0, d); chk("R10", "new begin", d, 32'h6004);
        rd_creg(2'd1, d); chk("R10", "new end", d, 32'h6011);
        rd_creg(2'd2, d); chk("R10", "decrement dropped", d, 32'h3);
        setup_cmd(1'b0, 32'h7000, 32'h4, 32'h0);
        drive(1'b1, 1'b0, 32'h8000, 32'h8, 32'h9, 1'b1, 2'd0, 32'hDEAD_0000,
              1'b1, 32'h7004, r, t);
        chk("R10", "exhausted old loop no redirect", {31'b0, r}, 32'h0);
        chk("R10", "new loop armed", {31'b0, loop_active}, 32'h1);
        rd_creg(2'd2, d); chk("R10", "new count", d, 32'h9);
        rd_creg(2'd0, d); chk("R10", "setup beats write", d, 32'h8004);
        rd_creg(2'd1, d); chk("R10", "new counted end", d, 32'h8008);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule